// File: doc/BRIEF.md
# Microcode Sequencer with Interrupt Injection

This block is the sequencing core of a small microcoded 8-bit processor. It keeps the current opcode, a phase counter that steps through the cycles of one instruction, a four-bit condition-code register and an interrupt enable bit. It presents these as one control-store address. The upper byte is the opcode, the next nibble is the phase and the low nibble holds all four flags, so every flag can steer the microcode at the same time.

The microcode ends an instruction with an end-of-instruction control bit. In the cycle that follows, the block fetches a new opcode from its data input. If interrupts are enabled and a request is pending at that fetch, the opcode register clears to opcode 0, the interrupt entry instruction, and does not load the fetched byte. The flags load in parallel from the ALU. They can also be restored one bit per cycle through a serial path, which takes four cycles.

Top module: `usq_sequencer`

## Requirements
- R1: `cs_addr` is `{opcode, phase, flags}`. The opcode is in bits 15..8, the phase in bits 7..4 and the flags in bits 3..0.
- R2: While `rst_n` is low, the opcode, phase, flags, `int_en` and `fetch` are all 0. The internal reset ends at the second rising clock edge after `rst_n` goes high, and the registers first update at the third edge.
- R3: `end_instr` high at a clock edge makes `fetch` high for the next cycle. At the edge that closes that cycle, the opcode register takes `op_in`. Outside a fetch cycle, the opcode holds its value.
- R4: At the edge that closes a fetch cycle, if `int_en` is 1 and `irq_pending` is 1, the opcode becomes 0x00 and `op_in` is ignored. A pending request has no effect while `int_en` is 0, and it has no effect outside a fetch cycle.
- R5: The phase returns to 0 at the edge that closes a fetch cycle. At every other edge it increases by 1, and it wraps from 15 to 0, so an instruction has at most 16 cycles.
- R6: `ie_set` sets `int_en` and `ie_clr` clears it. When both are high, clearing wins. With neither high, `int_en` holds.
- R7: `flag_load` copies `alu_flags` into the flags in one edge. With neither `flag_load` nor `flag_shift` high, the flags hold.
- R8: `flag_shift` without `flag_load` moves the flags one place toward bit 0 and puts `flag_sin` in bit 3. After four shifts of bits b0, b1, b2 and b3, in that order, the flags read {b3,b2,b1,b0}. `flag_load` takes priority over `flag_shift`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_in | input | 8 | Opcode byte fetched from memory |
| end_instr | input | 1 | Control bit: the current instruction ends, so fetch in the next cycle |
| irq_pending | input | 1 | An interrupt request is waiting |
| ie_set | input | 1 | Control bit: enable interrupts |
| ie_clr | input | 1 | Control bit: disable interrupts |
| flag_load | input | 1 | Control bit: load the flags from the ALU |
| alu_flags | input | 4 | Flag outputs of the ALU |
| flag_shift | input | 1 | Control bit: shift one saved flag bit in |
| flag_sin | input | 1 | Serial flag bit being restored |
| cs_addr | output | 16 | Control-store address {opcode, phase, flags} |
| fetch | output | 1 | High during the opcode fetch cycle |
| int_en | output | 1 | Interrupt enable state |

## Verification
Assertions check the following on every cycle:
- a fetch cycle follows each end-of-instruction bit;
- the opcode holds outside a fetch cycle, and at a fetch it takes the input byte or zero depending on the interrupt condition;
- the phase restarts after a fetch and otherwise steps by one, wrapping;
- the interrupt enable bit obeys set and clear, with clear winning;
- the flags load, shift or hold as commanded.

Only the bench scenarios show the following:
- the exact reset-release latency;
- a pending request being ignored between fetches or while interrupts are disabled;
- the bit order of a complete four-cycle serial restore;
- load winning over shift;
- the full concatenated address after a sequence of instructions.

// File: rtl/usq_pkg.sv
`timescale 1ns/1ps
package usq_pkg;
  parameter int unsigned OPC_W  = 8;
  parameter int unsigned PHS_W  = 4;
  parameter int unsigned FLG_W  = 4;
  parameter int unsigned CSA_W  = OPC_W + PHS_W + FLG_W;
  parameter int unsigned IRQ_OPCODE = 0;
  parameter int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/usq_rst_sync.sv
`timescale 1ns/1ps
// Reset synchronizer: asserts at once, releases after STAGES clock edges.
module usq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/usq_opcode_reg.sv
`timescale 1ns/1ps
// Opcode register: loads at fetch; clears to the interrupt opcode instead when an interrupt is taken.
module usq_opcode_reg #(
  parameter int unsigned W      = 8,
  parameter int unsigned INT_OP = 0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         fetch_i,
  input  logic         take_int_i,
  input  logic [W-1:0] op_i,
  output logic [W-1:0] op_o
);
  localparam logic [W-1:0] IntCode = W'(INT_OP);

  logic [W-1:0] op_q;
  logic [W-1:0] op_d;

  always_comb begin
    op_d = op_q;
    if (fetch_i) begin
      if (take_int_i) op_d = IntCode;
      else            op_d = op_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) op_q <= '0;
    else         op_q <= op_d;
  end

  assign op_o = op_q;

  // R3: outside a fetch cycle the opcode does not move
  p_hold_outside_fetch_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !fetch_i |=> $stable(op_o));
  // R3: a fetch with no interrupt takes the presented byte
  p_load_at_fetch_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (fetch_i && !take_int_i) |=> (op_o == $past(op_i)));
  // R4: a taken interrupt forces the entry opcode
  p_int_forces_zero_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (fetch_i && take_int_i) |=> (op_o == IntCode));
endmodule

// File: rtl/usq_phase_ctr.sv
`timescale 1ns/1ps
// Phase counter: restarts at 0 after a fetch, otherwise steps and wraps.
module usq_phase_ctr #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         restart_i,
  output logic [W-1:0] phase_o
);
  localparam logic [W-1:0] One = W'(1);

  logic [W-1:0] ph_q;
  logic [W-1:0] ph_d;

  always_comb begin
    if (restart_i) ph_d = '0;
    else           ph_d = ph_q + One;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  assign phase_o = ph_q;

  // R5: phase is zero in the first cycle of a new opcode
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    restart_i |=> (phase_o == '0));
  // R5: otherwise one step per cycle, wrapping at the counter width
  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    !restart_i |=> (phase_o == W'($past(phase_o) + One)));
endmodule

// File: rtl/usq_flag_reg.sv
`timescale 1ns/1ps
// Condition-code register: parallel load from the ALU, serial restore toward bit 0.
module usq_flag_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] par_i,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] fl_q;
  logic [W-1:0] fl_d;

  always_comb begin
    fl_d = fl_q;
    if (load_i)       fl_d = par_i;
    else if (shift_i) fl_d = {ser_i, fl_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) fl_q <= '0;
    else         fl_q <= fl_d;
  end

  assign flags_o = fl_q;

  // R7: parallel load lands in one edge
  p_parallel_load_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |=> (flags_o == $past(par_i)));
  // R7: no command leaves the flags untouched
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(flags_o));
  // R8: serial bit enters at the top
  p_serial_top_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (flags_o[W-1] == $past(ser_i)));
  // R8: the remaining bits move one place toward bit 0
  p_serial_move_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (flags_o[W-2:0] == $past(flags_o[W-1:1])));
endmodule

// File: rtl/usq_sequencer.sv
`timescale 1ns/1ps
// Microcode sequencer: forms {opcode, phase, flags} and injects the interrupt opcode at fetch.
module usq_sequencer
  import usq_pkg::*;
#(
  parameter int unsigned OP_W  = OPC_W,
  parameter int unsigned PH_W  = PHS_W,
  parameter int unsigned FL_W  = FLG_W,
  parameter int unsigned INT_OP = IRQ_OPCODE,
  parameter int unsigned RS_STAGES = SYNC_STAGES,
  localparam int unsigned A_W = OP_W + PH_W + FL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_in,
  input  logic            end_instr,
  input  logic            irq_pending,
  input  logic            ie_set,
  input  logic            ie_clr,
  input  logic            flag_load,
  input  logic [FL_W-1:0] alu_flags,
  input  logic            flag_shift,
  input  logic            flag_sin,
  output logic [A_W-1:0]  cs_addr,
  output logic            fetch,
  output logic            int_en
);
  logic            rst_i_n;
  logic            fetch_q, fetch_d;
  logic            ie_q, ie_d;
  logic            take_int;
  logic [OP_W-1:0] opcode;
  logic [PH_W-1:0] phase;
  logic [FL_W-1:0] flags;

  usq_rst_sync #(.STAGES(RS_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Next-state logic for fetch request and interrupt enable
  always_comb begin
    fetch_d = end_instr;
    ie_d    = ie_q;
    if (ie_clr)      ie_d = 1'b0;
    else if (ie_set) ie_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      fetch_q <= 1'b0;
      ie_q    <= 1'b0;
    end else begin
      fetch_q <= fetch_d;
      ie_q    <= ie_d;
    end
  end

  assign take_int = ie_q & irq_pending;

  usq_opcode_reg #(.W(OP_W), .INT_OP(INT_OP)) u_opcode (
    .clk        (clk),
    .rst_ni     (rst_i_n),
    .fetch_i    (fetch_q),
    .take_int_i (take_int),
    .op_i       (op_in),
    .op_o       (opcode)
  );

  usq_phase_ctr #(.W(PH_W)) u_phase (
    .clk       (clk),
    .rst_ni    (rst_i_n),
    .restart_i (fetch_q),
    .phase_o   (phase)
  );

  usq_flag_reg #(.W(FL_W)) u_flags (
    .clk     (clk),
    .rst_ni  (rst_i_n),
    .load_i  (flag_load),
    .par_i   (alu_flags),
    .shift_i (flag_shift),
    .ser_i   (flag_sin),
    .flags_o (flags)
  );

  assign cs_addr = {opcode, phase, flags};
  assign fetch   = fetch_q;
  assign int_en  = ie_q;

  // R3: an end-of-instruction bit is followed by a fetch cycle
  p_fetch_follows_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    end_instr |=> fetch);
  // R6: clear wins over set
  p_ie_clear_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    ie_clr |=> !int_en);
  // R6: set alone enables
  p_ie_set_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ie_set && !ie_clr) |=> int_en);
  // R6: no command keeps the state
  p_ie_hold_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!ie_set && !ie_clr) |=> $stable(int_en));
endmodule

// File: tb/usq_sequencer_tb.sv
`timescale 1ns/1ps
module usq_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  op_in;
  logic        end_instr, irq_pending, ie_set, ie_clr;
  logic        flag_load, flag_shift, flag_sin;
  logic [3:0]  alu_flags;
  logic [15:0] cs_addr;
  logic        fetch, int_en;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit started  = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_s1, m_s2, m_fetch, m_ie, in_rst;
  int m_op, m_ph, m_fl;
  int n_op, n_ph, n_fl;
  bit n_fetch, n_ie;

  always #2.5 clk = ~clk;

  usq_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .op_in(op_in), .end_instr(end_instr),
    .irq_pending(irq_pending), .ie_set(ie_set), .ie_clr(ie_clr),
    .flag_load(flag_load), .alu_flags(alu_flags), .flag_shift(flag_shift),
    .flag_sin(flag_sin), .cs_addr(cs_addr), .fetch(fetch), .int_en(int_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0;
      m_op = 0; m_ph = 0; m_fl = 0; m_ie = 0; m_fetch = 0;
    end else begin
      in_rst = !m_s2;
      m_s2 = m_s1;
      m_s1 = 1;
      if (in_rst) begin
        m_op = 0; m_ph = 0; m_fl = 0; m_ie = 0; m_fetch = 0;
      end else begin
        n_fetch = end_instr;
        n_op = m_op;
        if (m_fetch) n_op = (m_ie && irq_pending) ? 0 : int'(op_in);
        n_ph = m_fetch ? 0 : (m_ph + 1) % 16;
        if (flag_load)       n_fl = int'(alu_flags);
        else if (flag_shift) n_fl = (int'(flag_sin) << 3) | (m_fl >> 1);
        else                 n_fl = m_fl;
        n_ie = ie_clr ? 1'b0 : (ie_set ? 1'b1 : m_ie);
        m_op = n_op; m_ph = n_ph; m_fl = n_fl; m_ie = n_ie; m_fetch = n_fetch;
      end
    end
  end

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (started && !finished) begin
      check("R3 R4 opcode field", int'(cs_addr[15:8]), m_op);
      check("R5 phase field", int'(cs_addr[7:4]), m_ph);
      check("R7 R8 flag field", int'(cs_addr[3:0]), m_fl);
      check("R6 int_en", int'(int_en), int'(m_ie));
      check("R3 fetch", int'(fetch), int'(m_fetch));
    end
    if (cycles > 100000 && !finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fetch_op(input logic [7:0] b);
    end_instr = 1; tick(1);
    check("R3 fetch after end bit", int'(fetch), 1);
    end_instr = 0; op_in = b; tick(1);
  endtask

  initial begin
    rst_n = 0; op_in = 0; end_instr = 0; irq_pending = 0; ie_set = 0; ie_clr = 0;
    flag_load = 0; alu_flags = 0; flag_shift = 0; flag_sin = 0;
    tick(4);
    started = 1;
    check("R2 reset address", int'(cs_addr), 0);
    check("R2 reset int_en", int'(int_en), 0);
    check("R2 reset fetch", int'(fetch), 0);
    rst_n = 1;
    tick(2);
    check("R2 still reset after two edges", int'(cs_addr[7:4]), 0);
    tick(1);
    check("R2 first update at third edge", int'(cs_addr[7:4]), 1);

    // R3 / R5 / R1: plain fetch and phase stepping
    fetch_op(8'h3C);
    check("R3 opcode loaded", int'(cs_addr[15:8]), 'h3C);
    check("R5 phase restart", int'(cs_addr[7:4]), 0);
    tick(5);
    check("R1 address layout", int'(cs_addr), 'h3C50);
    tick(10);
    check("R5 phase at 15", int'(cs_addr[7:4]), 15);
    tick(1);
    check("R5 phase wrap", int'(cs_addr[7:4]), 0);
    check("R3 opcode held", int'(cs_addr[15:8]), 'h3C);

    // R6 / R4: interrupt injection
    ie_set = 1; tick(1); ie_set = 0;
    check("R6 set", int'(int_en), 1);
    irq_pending = 1; tick(3);
    check("R4 pending outside fetch ignored", int'(cs_addr[15:8]), 'h3C);
    fetch_op(8'h77);
    check("R4 interrupt opcode", int'(cs_addr[15:8]), 0);
    irq_pending = 0;
    ie_set = 1; ie_clr = 1; tick(1); ie_set = 0; ie_clr = 0;
    check("R6 clear wins", int'(int_en), 0);
    tick(2);
    check("R6 hold", int'(int_en), 0);
    irq_pending = 1;
    fetch_op(8'h5A);
    check("R4 disabled request ignored", int'(cs_addr[15:8]), 'h5A);
    irq_pending = 0;

    // R7 / R8: flag paths
    flag_load = 1; alu_flags = 4'hA; tick(1); flag_load = 0; alu_flags = 0;
    check("R7 parallel load", int'(cs_addr[3:0]), 'hA);
    tick(2);
    check("R7 hold", int'(cs_addr[3:0]), 'hA);
    flag_shift = 1;
    flag_sin = 1; tick(1);
    flag_sin = 0; tick(1);
    flag_sin = 1; tick(1);
    flag_sin = 1; tick(1);
    flag_shift = 0; flag_sin = 0;
    check("R8 serial restore order", int'(cs_addr[3:0]), 'hD);
    flag_load = 1; alu_flags = 4'h3; flag_shift = 1; flag_sin = 1; tick(1);
    flag_load = 0; flag_shift = 0; flag_sin = 0;
    check("R8 load over shift", int'(cs_addr[3:0]), 3);

    // back-to-back end bits
    end_instr = 1; op_in = 8'h11; tick(2); end_instr = 0; op_in = 8'h22; tick(2);
    check("R3 back-to-back fetch", int'(cs_addr[15:8]), 'h22);
    tick(3);
    finished = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule